// File: doc/BRIEF.md
# Two-Level I/O Address Translator

This block turns a 32-bit I/O virtual address into a 40-bit physical address for a DMA engine. It walks a two-level table of 4 KiB pages kept in memory: a top-level directory picked by the upper ten address bits, and a second-level page table picked by the next ten bits. The low twelve bits pass through as the page offset. Each walk step is a single 32-bit read on a simple read port that has one request in flight and any response latency.

A request carries the virtual address and a write flag. The block first looks in a four-entry, fully associative translation cache. On a hit it answers without touching memory. On a miss it reads the directory entry and then the page entry. It returns either the physical address or a fault with a one-hot cause, and it echoes the virtual address with the result. Valid translations go into the cache in round-robin order. A one-cycle flush pulse empties the cache.

Only one request is handled at a time. The requester waits for the ready signal.

Top module: `iova_xlate`

## Requirements
- R1: The directory entry is read at address {dir_base_word[31:10], 10'b0} + iova[31:22]*4. Bits 9:0 of dir_base_word, which carry the page-size mode (0 = 4 KiB), have no effect on the address.
- R2: A directory entry whose bit 0 is 0 ends the walk after that one read, with resp_fault=1 and resp_cause=3'b001. All other bits of such an entry are ignored.
- R3: The page entry is read at address (directory entry AND 0xFFFFFFC0) + iova[21:12]*4.
- R4: A page entry whose bit 0 is 0 gives resp_fault=1 and resp_cause=3'b010. It is never cached, so a repeat of the same request walks memory again.
- R5: For a valid page entry, resp_pa[31:12] = entry[31:12], resp_pa[39:32] = entry[11:4], and resp_pa[11:0] = iova[11:0].
- R6: A write request (req_write=1) to a page whose entry bit 2 is 0 gives resp_fault=1 and resp_cause=3'b100. This holds for a fresh walk and for a cache hit. A read of the same page succeeds.
- R7: Every result is a one-cycle resp_valid pulse carrying resp_iova equal to the accepted address. resp_cause is 0 and resp_fault is 0 on success. On a fault, resp_pa is 0 and resp_cause is one-hot.
- R8: A cache hit issues no memory read and answers one cycle after the accepting edge. A miss issues each read as a one-cycle mem_req pulse; the next read goes out, or the result appears, one cycle after mem_rvalid.
- R9: The cache holds 4 translations and replaces them in round-robin order. The fifth distinct page evicts the first one filled.
- R10: A flush pulse empties the cache at the next edge, so later requests walk memory again even if the cache held stale entries. A walk that sees a flush while in progress returns its result but does not cache it.
- R11: req_ready is high only while idle. It drops the cycle after acceptance and stays low until the result. A req_valid raised while busy is ignored and produces no read and no result.
- R12: Synchronous active-low reset leaves req_ready=1, resp_valid=0 and mem_req=0, and empties the cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | High while idle and able to accept |
| req_iova | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is for a write access |
| dir_base_word | input | 32 | Directory base in bits 31:10, mode bits below |
| flush | input | 1 | One-cycle pulse that empties the cache |
| mem_req | output | 1 | One-cycle read request pulse |
| mem_addr | output | 32 | Byte address of the 32-bit word to read |
| mem_rvalid | input | 1 | Read data valid, one cycle |
| mem_rdata | input | 32 | Read data word |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_fault | output | 1 | Result is a fault |
| resp_cause | output | 3 | One-hot fault cause: 001 directory, 010 page, 100 write protect |
| resp_pa | output | 40 | Physical address, 0 on fault |
| resp_iova | output | 32 | Virtual address the result belongs to |

## Verification
A cache hit must show its result at the first edge after the accepting edge. A directory fault is due one edge after the single read returns, and a full walk one edge after the second read returns. The bench memory answers each read a fixed two cycles after seeing the pulse, so these come to exactly 1, 4 and 7 edges after acceptance. The bench drives and samples on falling edges, counts rising edges from acceptance until resp_valid appears, and compares that count and the number of read pulses against the exact values. A result that arrives early, late or after an extra read therefore fails.

// File: rtl/iovx_pkg.sv
// iovx_pkg: shared widths, field positions, fault codes and walk states
// for the two-level address translator. The field positions follow the
// in-memory entry formats and must not be changed independently.
package iovx_pkg;

    localparam int VA_W        = 32;              // virtual address width
    localparam int PA_W        = 40;              // physical address width
    localparam int WORD_W      = 32;              // table entry / read width
    localparam int PG_SH       = 12;              // 4 KiB page offset bits
    localparam int IX_W        = 10;              // index bits per level
    localparam int ENT_BYTES   = 4;               // bytes per table entry
    localparam int ENT_SH      = $clog2(ENT_BYTES);
    localparam int DIR_LSB     = PG_SH + IX_W;    // lowest directory index bit
    localparam int VPN_W       = VA_W - PG_SH;    // virtual page number width
    localparam int PPN_W       = PA_W - PG_SH;    // physical page number width
    localparam int HI_W        = PA_W - VA_W;     // physical bits above 32
    localparam int HI_LSB      = PG_SH - HI_W;    // entry bit holding PA[32]
    localparam int PT_ALIGN    = 6;               // page table pointer alignment
    localparam int DBASE_LSB   = 10;              // directory base lowest bit
    localparam int VALID_BIT   = 0;               // valid flag in both entries
    localparam int WRITE_BIT   = 2;               // writable flag in page entry

    typedef logic [2:0] cause_t;
    localparam cause_t CAUSE_NONE = 3'b000;
    localparam cause_t CAUSE_DIR  = 3'b001;
    localparam cause_t CAUSE_PAGE = 3'b010;
    localparam cause_t CAUSE_WP   = 3'b100;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_LOOK = 2'd1,
        W_DIR  = 2'd2,
        W_PAGE = 2'd3
    } wstate_t;

endpackage

// File: rtl/iovx_entry_dec.sv
// iovx_entry_dec: splits a 32-bit word read from memory into the fields of
// a directory entry and of a page entry. Purely combinational. The caller
// decides which interpretation applies in the current walk step.
module iovx_entry_dec
    import iovx_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              dir_ok,
    output logic [WORD_W-1:0] pt_base,
    output logic              pg_ok,
    output logic              pg_wr,
    output logic [PPN_W-1:0]  pg_ppn
);

    logic unused_bits;

    // Directory entry: valid flag and 64-byte aligned table pointer.
    always_comb begin
        dir_ok  = word[VALID_BIT];
        pt_base = {word[WORD_W-1:PT_ALIGN], {PT_ALIGN{1'b0}}};
    end

    // Page entry: flags, plus the page number with its upper bits unpacked.
    always_comb begin
        pg_ok  = word[VALID_BIT];
        pg_wr  = word[WRITE_BIT];
        pg_ppn = {word[PG_SH-1:HI_LSB], word[WORD_W-1:PG_SH]};
    end

    assign unused_bits = word[3] ^ word[1];

endmodule

// File: rtl/iovx_tlb.sv
// iovx_tlb: small fully associative translation cache. Lookup is
// combinational; fills and flushes take effect at the clock edge. Fills go
// to the slot under a round-robin pointer. Assumes the caller never fills a
// page that currently hits, so each page occupies at most one slot.
module iovx_tlb
    import iovx_pkg::*;
#(
    parameter int N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             hit,
    output logic [PPN_W-1:0] hit_ppn,
    output logic             hit_wr,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_wr
);

    localparam int PTR_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(N - 1);

    logic             vld_q [N];
    logic [VPN_W-1:0] vpn_q [N];
    logic [PPN_W-1:0] ppn_q [N];
    logic             wr_q  [N];
    logic [PTR_W-1:0] ptr_q;
    logic [N-1:0]     match;

    // Per-slot tag comparators.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = vld_q[g] && (vpn_q[g] == lk_vpn);
    end

    // Select the matching slot's payload.
    always_comb begin
        hit     = |match;
        hit_ppn = '0;
        hit_wr  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) begin
                hit_ppn = hit_ppn | ppn_q[i];
                hit_wr  = hit_wr | wr_q[i];
            end
        end
    end

    // Slot storage: reset and flush clear valid bits, a fill writes one slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                vld_q[i] <= 1'b0;
                vpn_q[i] <= '0;
                ppn_q[i] <= '0;
                wr_q[i]  <= 1'b0;
            end
        end else if (flush) begin
            for (int i = 0; i < N; i++) begin
                vld_q[i] <= 1'b0;
            end
        end else if (fill_en) begin
            for (int i = 0; i < N; i++) begin
                if (ptr_q == PTR_W'(i)) begin
                    vld_q[i] <= 1'b1;
                    vpn_q[i] <= fill_vpn;
                    ppn_q[i] <= fill_ppn;
                    wr_q[i]  <= fill_wr;
                end
            end
        end
    end

    // Round-robin victim pointer, advanced on each accepted fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (fill_en && !flush) begin
            ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
        end
    end

endmodule

// File: rtl/iovx_walk_ctl.sv
// iovx_walk_ctl: sequencer for one translation at a time. It accepts a
// request, checks the cache, and on a miss issues the directory read and
// then the page read. It registers the result as a one-cycle pulse. It
// assumes the read port answers every request exactly once with
// mem_rvalid, and that no mem_rvalid arrives unasked.
module iovx_walk_ctl
    import iovx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_iova,
    input  logic              req_write,
    input  logic [WORD_W-1:0] dir_base_word,
    input  logic              flush,
    input  logic              mem_rvalid,
    input  logic              dir_ok,
    input  logic [WORD_W-1:0] pt_base,
    input  logic              pg_ok,
    input  logic              pg_wr,
    input  logic [PPN_W-1:0]  pg_ppn,
    input  logic              tlb_hit,
    input  logic [PPN_W-1:0]  tlb_ppn,
    input  logic              tlb_wr,
    output logic [VPN_W-1:0]  lk_vpn,
    output logic              fill_en,
    output logic [VPN_W-1:0]  fill_vpn,
    output logic [PPN_W-1:0]  fill_ppn,
    output logic              fill_wr,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    output logic              resp_valid,
    output logic              resp_fault,
    output cause_t            resp_cause,
    output logic [PA_W-1:0]   resp_pa,
    output logic [VA_W-1:0]   resp_iova
);

    wstate_t           st_q;
    logic [VA_W-1:0]   va_q;
    logic              wr_q;
    logic              stale_q;
    logic              mreq_q;
    logic [WORD_W-1:0] maddr_q;
    logic              rv_q;
    logic              rf_q;
    cause_t            rc_q;
    logic [PA_W-1:0]   rpa_q;

    logic              done_c;
    cause_t            cause_c;
    logic [PPN_W-1:0]  ppn_c;
    logic [WORD_W-1:0] dir_addr_c;
    logic [WORD_W-1:0] pg_addr_c;
    logic              unused_base;

    assign unused_base = ^dir_base_word[DBASE_LSB-1:0];

    // Entry addresses: table base plus index scaled by the entry size.
    always_comb begin
        dir_addr_c = {dir_base_word[WORD_W-1:DBASE_LSB], {DBASE_LSB{1'b0}}}
                   + WORD_W'({va_q[VA_W-1:DIR_LSB], {ENT_SH{1'b0}}});
        pg_addr_c  = pt_base
                   + WORD_W'({va_q[DIR_LSB-1:PG_SH], {ENT_SH{1'b0}}});
    end

    // Decide whether this cycle ends the translation, and with which result.
    always_comb begin
        done_c  = 1'b0;
        cause_c = CAUSE_NONE;
        ppn_c   = tlb_ppn;
        unique case (st_q)
            W_LOOK: begin
                if (tlb_hit) begin
                    done_c  = 1'b1;
                    cause_c = (wr_q && !tlb_wr) ? CAUSE_WP : CAUSE_NONE;
                end
            end
            W_DIR: begin
                if (mem_rvalid && !dir_ok) begin
                    done_c  = 1'b1;
                    cause_c = CAUSE_DIR;
                end
            end
            W_PAGE: begin
                if (mem_rvalid) begin
                    done_c = 1'b1;
                    ppn_c  = pg_ppn;
                    if (!pg_ok) begin
                        cause_c = CAUSE_PAGE;
                    end else if (wr_q && !pg_wr) begin
                        cause_c = CAUSE_WP;
                    end
                end
            end
            default: begin
                done_c = 1'b0;
            end
        endcase
    end

    // Cache fill request: valid page entry from a walk not hit by a flush.
    always_comb begin
        lk_vpn   = va_q[VA_W-1:PG_SH];
        fill_en  = (st_q == W_PAGE) && mem_rvalid && pg_ok && !stale_q && !flush;
        fill_vpn = va_q[VA_W-1:PG_SH];
        fill_ppn = pg_ppn;
        fill_wr  = pg_wr;
    end

    // Walk state, read requests and latched request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= W_IDLE;
            va_q    <= '0;
            wr_q    <= 1'b0;
            stale_q <= 1'b0;
            mreq_q  <= 1'b0;
            maddr_q <= '0;
        end else begin
            mreq_q <= 1'b0;
            if (flush && st_q != W_IDLE) begin
                stale_q <= 1'b1;
            end
            unique case (st_q)
                W_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_iova;
                        wr_q    <= req_write;
                        stale_q <= 1'b0;
                        st_q    <= W_LOOK;
                    end
                end
                W_LOOK: begin
                    if (tlb_hit) begin
                        st_q <= W_IDLE;
                    end else begin
                        mreq_q  <= 1'b1;
                        maddr_q <= dir_addr_c;
                        st_q    <= W_DIR;
                    end
                end
                W_DIR: begin
                    if (mem_rvalid) begin
                        if (dir_ok) begin
                            mreq_q  <= 1'b1;
                            maddr_q <= pg_addr_c;
                            st_q    <= W_PAGE;
                        end else begin
                            st_q <= W_IDLE;
                        end
                    end
                end
                W_PAGE: begin
                    if (mem_rvalid) begin
                        st_q <= W_IDLE;
                    end
                end
                default: begin
                    st_q <= W_IDLE;
                end
            endcase
        end
    end

    // Result register: one-cycle pulse, address cleared on a fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rv_q  <= 1'b0;
            rf_q  <= 1'b0;
            rc_q  <= CAUSE_NONE;
            rpa_q <= '0;
        end else begin
            rv_q <= done_c;
            if (done_c) begin
                rf_q  <= (cause_c != CAUSE_NONE);
                rc_q  <= cause_c;
                rpa_q <= (cause_c == CAUSE_NONE) ? {ppn_c, va_q[PG_SH-1:0]} : '0;
            end
        end
    end

    assign req_ready  = (st_q == W_IDLE);
    assign mem_req    = mreq_q;
    assign mem_addr   = maddr_q;
    assign resp_valid = rv_q;
    assign resp_fault = rf_q;
    assign resp_cause = rc_q;
    assign resp_pa    = rpa_q;
    assign resp_iova  = va_q;

endmodule

// File: rtl/iova_xlate.sv
// iova_xlate: two-level I/O address translator with a small cache.
// It ties the walk sequencer, the entry decoder on the read-data path and
// the translation cache together. It assumes a single outstanding read on
// the memory port and one request at a time from the requester.
module iova_xlate
    import iovx_pkg::*;
#(
    parameter int TLB_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_iova,
    input  logic              req_write,
    input  logic [WORD_W-1:0] dir_base_word,
    input  logic              flush,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              resp_valid,
    output logic              resp_fault,
    output logic [2:0]        resp_cause,
    output logic [PA_W-1:0]   resp_pa,
    output logic [VA_W-1:0]   resp_iova
);

    logic              dir_ok;
    logic [WORD_W-1:0] pt_base;
    logic              pg_ok;
    logic              pg_wr;
    logic [PPN_W-1:0]  pg_ppn;
    logic              tlb_hit;
    logic [PPN_W-1:0]  tlb_ppn;
    logic              tlb_wr;
    logic [VPN_W-1:0]  lk_vpn;
    logic              fill_en;
    logic [VPN_W-1:0]  fill_vpn;
    logic [PPN_W-1:0]  fill_ppn;
    logic              fill_wr;

    iovx_entry_dec u_dec (
        .word    (mem_rdata),
        .dir_ok  (dir_ok),
        .pt_base (pt_base),
        .pg_ok   (pg_ok),
        .pg_wr   (pg_wr),
        .pg_ppn  (pg_ppn)
    );

    iovx_tlb #(.N(TLB_N)) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .lk_vpn   (lk_vpn),
        .hit      (tlb_hit),
        .hit_ppn  (tlb_ppn),
        .hit_wr   (tlb_wr),
        .fill_en  (fill_en),
        .fill_vpn (fill_vpn),
        .fill_ppn (fill_ppn),
        .fill_wr  (fill_wr)
    );

    iovx_walk_ctl u_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_iova      (req_iova),
        .req_write     (req_write),
        .dir_base_word (dir_base_word),
        .flush         (flush),
        .mem_rvalid    (mem_rvalid),
        .dir_ok        (dir_ok),
        .pt_base       (pt_base),
        .pg_ok         (pg_ok),
        .pg_wr         (pg_wr),
        .pg_ppn        (pg_ppn),
        .tlb_hit       (tlb_hit),
        .tlb_ppn       (tlb_ppn),
        .tlb_wr        (tlb_wr),
        .lk_vpn        (lk_vpn),
        .fill_en       (fill_en),
        .fill_vpn      (fill_vpn),
        .fill_ppn      (fill_ppn),
        .fill_wr       (fill_wr),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .resp_valid    (resp_valid),
        .resp_fault    (resp_fault),
        .resp_cause    (resp_cause),
        .resp_pa       (resp_pa),
        .resp_iova     (resp_iova)
    );

endmodule

// File: rtl/iovx_xlate_chk.sv
// iovx_xlate_chk: protocol and result-format properties of iova_xlate,
// observed at its ports. Attached to every instance by the bind below.
module iovx_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_iova,
    input logic        mem_req,
    input logic        resp_valid,
    input logic        resp_fault,
    input logic [2:0]  resp_cause,
    input logic [39:0] resp_pa,
    input logic [31:0] resp_iova
);

    logic [31:0] held_q;

    // Remember the address of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (req_valid && req_ready) begin
            held_q <= req_iova;
        end
    end

    p_resp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid)
        else $error("result strobe longer than one cycle");

    p_cause_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $onehot0(resp_cause))
        else $error("fault cause not one-hot");

    p_fault_pa_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (resp_pa == 40'd0 && resp_cause != 3'd0))
        else $error("fault with address or without cause");

    p_ok_no_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_fault) |-> (resp_cause == 3'd0))
        else $error("success carrying a cause");

    p_echo_iova_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_iova == held_q))
        else $error("result for a different address");

    p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready)
        else $error("ready after acceptance");

    p_read_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req)
        else $error("read request longer than one cycle");

    p_read_only_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready)
        else $error("read issued while idle");

endmodule

bind iova_xlate iovx_xlate_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_iova   (req_iova),
    .mem_req    (mem_req),
    .resp_valid (resp_valid),
    .resp_fault (resp_fault),
    .resp_cause (resp_cause),
    .resp_pa    (resp_pa),
    .resp_iova  (resp_iova)
);

// File: tb/sim_iova_xlate.sv
`timescale 1ns/1ps
module sim_iova_xlate;

    localparam int RD_DLY = 2;     // extra negedges before a read answers
    localparam int NVEC   = 9;

    // {iova[32], write[1], cause[3], pa[40], latency[4]}
    localparam logic [79:0] VEC [NVEC] = '{
        {32'h0040_3ABC, 1'b0, 3'b000, 40'hAB_1234_5ABC, 4'd7},
        {32'h0040_3123, 1'b1, 3'b000, 40'hAB_1234_5123, 4'd1},
        {32'h0040_4010, 1'b0, 3'b000, 40'h01_0000_7010, 4'd7},
        {32'h0040_4FFF, 1'b1, 3'b100, 40'h00_0000_0000, 4'd1},
        {32'h0040_5000, 1'b0, 3'b010, 40'h00_0000_0000, 4'd7},
        {32'h0080_0004, 1'b0, 3'b001, 40'h00_0000_0000, 4'd4},
        {32'hFFC0_0FFF, 1'b0, 3'b000, 40'hFF_FFFF_FFFF, 4'd7},
        {32'h0040_5000, 1'b1, 3'b010, 40'h00_0000_0000, 4'd7},
        {32'hFFC0_0000, 1'b0, 3'b000, 40'hFF_FFFF_F000, 4'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_iova = '0;
    logic        req_write = 1'b0;
    logic [31:0] dir_base_word = 32'h0001_03FF;
    logic        flush = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        resp_valid;
    logic        resp_fault;
    logic [2:0]  resp_cause;
    logic [39:0] resp_pa;
    logic [31:0] resp_iova;

    int n_chk = 0;
    int n_bad = 0;
    int rd_cnt = 0;
    bit finished = 1'b0;

    logic [31:0] ma [32];
    logic [31:0] md [32];
    int          mn = 0;

    always #2 clk = ~clk;

    iova_xlate u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_iova      (req_iova),
        .req_write     (req_write),
        .dir_base_word (dir_base_word),
        .flush         (flush),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .mem_rvalid    (mem_rvalid),
        .mem_rdata     (mem_rdata),
        .resp_valid    (resp_valid),
        .resp_fault    (resp_fault),
        .resp_cause    (resp_cause),
        .resp_pa       (resp_pa),
        .resp_iova     (resp_iova)
    );

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        logic [31:0] d = 32'h0;
        for (int i = 0; i < mn; i++) if (ma[i] == a) d = md[i];
        return d;
    endfunction

    task automatic put(input logic [31:0] a, input logic [31:0] d);
        bit found = 1'b0;
        for (int i = 0; i < mn; i++) begin
            if (ma[i] == a) begin md[i] = d; found = 1'b1; end
        end
        if (!found) begin ma[mn] = a; md[mn] = d; mn++; end
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Memory responder: answers each read pulse RD_DLY negedges later.
    initial begin
        int cnt = 0;
        bit pend = 1'b0;
        logic [31:0] a = '0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (!rst_n) begin
                pend = 1'b0;
            end else begin
                if (mem_req) begin a = mem_addr; cnt = RD_DLY; pend = 1'b1; rd_cnt++; end
                if (pend) begin
                    if (cnt == 0) begin
                        mem_rvalid = 1'b1;
                        mem_rdata  = mem_rd(a);
                        pend = 1'b0;
                    end else begin
                        cnt--;
                    end
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_req(input logic [31:0] va, input logic wr, input logic [2:0] ecause,
                           input logic [39:0] epa, input int elat, input int flush_at,
                           input bit poke, input string tag);
        int k = 0;
        int r0;
        int ereads;
        bit got = 1'b0;
        ereads = (elat == 1) ? 0 : (elat == 4) ? 1 : 2;
        @(negedge clk);
        chk({tag, " R11 ready when idle"}, 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_iova = va; req_write = wr;
        @(posedge clk);
        r0 = rd_cnt;
        @(negedge clk);
        req_valid = 1'b0;
        while (!got && k < 40) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            flush = (flush_at != 0 && k == flush_at);
            if (poke && k == 1) begin
                chk({tag, " R11 ready low while busy"}, 64'(req_ready), 64'd0);
                req_valid = 1'b1; req_iova = 32'h0080_0000; req_write = 1'b0;
            end
            if (poke && k == 2) req_valid = 1'b0;
            if (resp_valid) got = 1'b1;
        end
        flush = 1'b0;
        chk({tag, " R8 latency"}, 64'(k), 64'(elat));
        chk({tag, " R8 read count"}, 64'(rd_cnt - r0), 64'(ereads));
        chk({tag, " R2 R4 R6 cause"}, 64'(resp_cause), 64'(ecause));
        chk({tag, " R7 fault flag"}, 64'(resp_fault), 64'(ecause != 3'd0));
        chk({tag, " R1 R3 R5 pa"}, 64'(resp_pa), 64'(epa));
        chk({tag, " R7 iova echo"}, 64'(resp_iova), 64'(va));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        put(32'h0001_0004, 32'h0002_007F);   // dir 1 -> table 0x20040
        put(32'h0001_0008, 32'h0003_00FE);   // dir 2 invalid
        put(32'h0001_0FFC, 32'h0004_0001);   // dir 1023 -> table 0x40000
        put(32'h0002_004C, 32'h1234_5AB5);
        put(32'h0002_0050, 32'h0000_7011);
        put(32'h0002_0054, 32'h0000_8004);
        put(32'h0002_0058, 32'h0000_9001);
        put(32'h0002_005C, 32'h0000_A005);
        put(32'h0004_0000, 32'hFFFF_FFF5);

        do_reset();
        // R12: reset state
        chk("R12 req_ready after reset", 64'(req_ready), 64'd1);
        chk("R12 resp_valid after reset", 64'(resp_valid), 64'd0);
        chk("R12 mem_req after reset", 64'(mem_req), 64'd0);

        // Vector table: walks, hits and faults (R1 to R8)
        for (int v = 0; v < NVEC; v++) begin
            run_req(VEC[v][79:48], VEC[v][47], VEC[v][46:44], VEC[v][43:4],
                    int'(VEC[v][3:0]), 0, 1'b0, $sformatf("vec%0d", v));
        end

        // R9: round-robin replacement
        run_req(32'h0040_6000, 1'b0, 3'b000, 40'h00_0000_9000, 7, 0, 1'b0, "R9 fill slot3");
        run_req(32'h0040_7ABC, 1'b0, 3'b000, 40'h00_0000_AABC, 7, 0, 1'b0, "R9 evict oldest");
        run_req(32'h0040_4004, 1'b0, 3'b000, 40'h01_0000_7004, 1, 0, 1'b0, "R9 second kept");
        run_req(32'h0040_3000, 1'b0, 3'b000, 40'hAB_1234_5000, 7, 0, 1'b0, "R9 oldest gone");
        run_req(32'hFFC0_0010, 1'b0, 3'b000, 40'hFF_FFFF_F010, 1, 0, 1'b0, "R9 third kept");

        // R10: stale hit, then flush forces a fresh walk
        put(32'h0004_0000, 32'h0000_1001);
        run_req(32'hFFC0_0010, 1'b0, 3'b000, 40'hFF_FFFF_F010, 1, 0, 1'b0, "R10 stale hit");
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        run_req(32'hFFC0_0010, 1'b0, 3'b000, 40'h00_0000_1010, 7, 0, 1'b0, "R10 after flush");
        run_req(32'hFFC0_0010, 1'b0, 3'b000, 40'h00_0000_1010, 1, 0, 1'b0, "R10 refilled");

        // R10: flush during a walk keeps the result out of the cache
        run_req(32'h0040_6000, 1'b0, 3'b000, 40'h00_0000_9000, 7, 2, 1'b0, "R10 flush mid walk");
        run_req(32'h0040_6000, 1'b0, 3'b000, 40'h00_0000_9000, 7, 0, 1'b0, "R10 not cached");
        run_req(32'h0040_6000, 1'b0, 3'b000, 40'h00_0000_9000, 1, 0, 1'b0, "R10 cached now");

        // R6: write protection on a walk and on a hit, read allowed
        run_req(32'h0040_4000, 1'b1, 3'b100, 40'h0, 7, 0, 1'b0, "R6 walk write");
        run_req(32'h0040_4000, 1'b1, 3'b100, 40'h0, 1, 0, 1'b0, "R6 hit write");
        run_req(32'h0040_4000, 1'b0, 3'b000, 40'h01_0000_7000, 1, 0, 1'b0, "R6 hit read");

        // R11: request while busy is ignored
        begin
            int r1;
            int extra = 0;
            run_req(32'h0040_7000, 1'b0, 3'b000, 40'h00_0000_A000, 7, 0, 1'b1, "R11 busy poke");
            r1 = rd_cnt;
            repeat (8) begin
                @(negedge clk);
                if (resp_valid) extra++;
            end
            chk("R11 no result from ignored request", 64'(extra), 64'd0);
            chk("R11 no read from ignored request", 64'(rd_cnt - r1), 64'd0);
        end

        // R12: reset empties the cache
        do_reset();
        run_req(32'h0040_7000, 1'b0, 3'b000, 40'h00_0000_A000, 7, 0, 1'b0, "R12 cache empty");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule